// File: doc/BRIEF.md
# Configuration Image Payload Size Extractor

This block watches a configuration image as it streams past, one byte per valid cycle with that byte's index beside it, and works out where the payload begins and how long it is. It never stores the image. It keeps only the few bytes it needs: a header-size byte at a fixed place, a record count, a short table of block records, a 16-bit component count, and a packed table of component sizes that it sums as the bits arrive.

The header-size byte points to the block record table. The byte just in front of that table holds the number of records. Each record is nine bytes long. It names a block and gives that block's start offset, and two block kinds matter here: the payload and the component-size table. The size table holds one 22-bit field per component. The fields sit back to back with no byte alignment. The payload length is the sum of all the fields multiplied by the frame size of 16 bytes. When the result is ready the block raises `done` and holds its outputs. If the image cannot be parsed it raises `parse_err` instead.

Top module: `isz_header_parse`

## Requirements
- R1: After reset, `done` and `parse_err` are low. `payload_start` and `data_size` read zero while `done` is low.
- R2: The header size is the byte at index 24. A header size below 26 raises `parse_err`.
- R3: The record count is the byte at index (header size − 1). Records are 9 bytes each and begin at index (header size). Within a record, byte 0 is the block kind and bytes 1..4 are a little-endian 32-bit start offset.
- R4: A record of kind 8 sets `payload_start` and a record of kind 5 sets the size-table start. Any other kind is ignored. A record whose start offset is zero counts as not found. If a kind repeats before both kinds are found, the later record wins.
- R5: Scanning stops at the first record after which both kinds have been found. Records after that point do not change `payload_start`.
- R6: If all records have been read and either kind is still missing, `parse_err` is raised. A record count of zero also raises `parse_err`.
- R7: The component count is a little-endian 16-bit value at indices 55..56. The size table must start at index 58 or later, and at least two indices past the byte that completes the scan. Otherwise `parse_err` is raised.
- R8: Component i is a 22-bit field whose bit j sits at table bit 22·i+j, counted LSB-first within each byte. `data_size` equals 16 × the sum of all fields.
- R9: A component count of zero yields `done` with `data_size` zero.
- R10: A valid byte flagged `in_last` that arrives while `done` is low leads to `parse_err` unless the result completes on that same byte.
- R11: `done` rises on the second clock edge after the byte that holds the last component field. `done` and `parse_err` are never high together, and each stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A byte is present this cycle |
| in_last | input | 1 | The present byte is the final one of the stream |
| in_idx | input | IDX_W | Index of the present byte; must increase from one byte to the next |
| in_byte | input | 8 | Byte value |
| payload_start | output | 32 | Payload start offset, valid when `done` is high |
| data_size | output | CNT_W+FIELD_W+log2(FRAME_BYTES) | Payload length in bytes, valid when `done` is high |
| done | output | 1 | Result ready; stays high until reset |
| parse_err | output | 1 | Image could not be parsed; stays high until reset |

## Verification
The bench builds the block with its defaults: a 32-bit index, a 16-bit count, 22-bit fields and a 16-byte frame. With a 16-byte frame the shift variant of the scaling stage is selected. The 32-bit index lets images be placed at header sizes from 60 to 200 with up to 40 components. Those component counts carry the bit accumulator through every residue of 22·i mod 8, and all-ones fields test the full width of the sum. Directed images move the size table, corrupt the record kinds and start offsets, and cut the stream short.

// File: rtl/isz_pkg.sv
package isz_pkg;
   localparam int BYTE_W     = 8;
   localparam int REC_BYTES  = 9;
   localparam int OFS_BYTES  = 4;
   localparam int OFS_W      = BYTE_W * OFS_BYTES;
   localparam int KIND_BYTE  = 0;

   typedef struct packed {
      logic             found;
      logic [OFS_W-1:0] ofs;
   } isz_ref_t;
endpackage

// File: rtl/isz_rec_scan.sv
module isz_rec_scan import isz_pkg::*; #(
   parameter int IDX_W   = 32,
   parameter int ID_PAY  = 8,
   parameter int ID_TAB  = 5,
   parameter int MIN_TAB = 58
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm,
   input  logic [IDX_W-1:0] base,
   input  logic [7:0]       nrec,
   input  logic             in_valid,
   input  logic [IDX_W-1:0] in_idx,
   input  logic [7:0]       in_byte,
   output logic             scan_done,
   output logic             scan_ok,
   output logic             scan_late,
   output logic [OFS_W-1:0] pay_ofs,
   output logic [OFS_W-1:0] tab_ofs
);
   localparam int K_W = $clog2(OFS_BYTES + 1);

   logic             active, done_q, ok_q, late_q;
   logic [K_W-1:0]   k_q;
   logic [7:0]       left_q;
   logic [IDX_W-1:0] next_q;
   logic [7:0]       kind_q;
   logic [OFS_W-9:0] lo_q;
   isz_ref_t         pay_q, tab_q;

   logic             hit, is_eval, last_rec, both;
   logic [OFS_W-1:0] full_ofs;
   isz_ref_t         pay_n, tab_n;
   logic [64:0]      tab_ext, idx_ext;

   assign hit      = active && in_valid && (in_idx == next_q);
   assign is_eval  = (k_q == K_W'(OFS_BYTES));
   assign full_ofs = {in_byte, lo_q};
   assign last_rec = (left_q == 8'd1);

   always_comb begin
      pay_n = pay_q;
      tab_n = tab_q;
      if (kind_q == 8'(ID_PAY) && full_ofs != '0) pay_n = '{found: 1'b1, ofs: full_ofs};
      if (kind_q == 8'(ID_TAB) && full_ofs != '0) tab_n = '{found: 1'b1, ofs: full_ofs};
      both    = pay_n.found && tab_n.found;
      tab_ext = 65'(tab_n.ofs);
      idx_ext = 65'(in_idx) + 65'd1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active <= 1'b0;
         done_q <= 1'b0;
         ok_q   <= 1'b0;
         late_q <= 1'b0;
         k_q    <= '0;
         left_q <= '0;
         next_q <= '0;
         kind_q <= '0;
         lo_q   <= '0;
         pay_q  <= '0;
         tab_q  <= '0;
      end else if (arm && !active && !done_q) begin
         if (nrec == 8'd0) begin
            done_q <= 1'b1;
         end else begin
            active <= 1'b1;
            next_q <= base;
            k_q    <= '0;
            left_q <= nrec;
         end
      end else if (hit) begin
         if (k_q == K_W'(KIND_BYTE)) begin
            kind_q <= in_byte;
            k_q    <= k_q + K_W'(1);
            next_q <= next_q + IDX_W'(1);
         end else if (!is_eval) begin
            lo_q   <= {in_byte, lo_q[OFS_W-9:8]};
            k_q    <= k_q + K_W'(1);
            next_q <= next_q + IDX_W'(1);
         end else begin
            pay_q <= pay_n;
            tab_q <= tab_n;
            if (both || last_rec) begin
               active <= 1'b0;
               done_q <= 1'b1;
               ok_q   <= both;
               late_q <= (tab_ext <= idx_ext) || (tab_ext < 65'(MIN_TAB));
            end else begin
               k_q    <= '0;
               next_q <= next_q + IDX_W'(REC_BYTES - OFS_BYTES);
               left_q <= left_q - 8'd1;
            end
         end
      end
   end

   assign scan_done = done_q;
   assign scan_ok   = ok_q;
   assign scan_late = late_q;
   assign pay_ofs   = pay_q.ofs;
   assign tab_ofs   = tab_q.ofs;
endmodule

// File: rtl/isz_field_sum.sv
module isz_field_sum #(
   parameter int IDX_W   = 32,
   parameter int CNT_W   = 16,
   parameter int FIELD_W = 22,
   parameter int SUM_W   = CNT_W + FIELD_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic [IDX_W-1:0] tab_start,
   input  logic [CNT_W-1:0] count,
   input  logic             in_valid,
   input  logic [IDX_W-1:0] in_idx,
   input  logic [7:0]       in_byte,
   output logic [SUM_W-1:0] sum,
   output logic             fin
);
   localparam int ACC_W = FIELD_W + 8;
   localparam int NB_W  = $clog2(ACC_W + 1);

   logic             run, fin_q;
   logic [IDX_W-1:0] next_q;
   logic [ACC_W-1:0] acc_q, merged;
   logic [NB_W-1:0]  nb_q, nb_add;
   logic [CNT_W-1:0] nfld_q;
   logic [SUM_W-1:0] sum_q;
   logic             hit, field_full;

   assign hit        = run && in_valid && (in_idx == next_q);
   assign merged     = acc_q | (ACC_W'(in_byte) << nb_q);
   assign nb_add     = nb_q + NB_W'(8);
   assign field_full = (nb_add >= NB_W'(FIELD_W));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run    <= 1'b0;
         fin_q  <= 1'b0;
         next_q <= '0;
         acc_q  <= '0;
         nb_q   <= '0;
         nfld_q <= '0;
         sum_q  <= '0;
      end else if (go && !run && !fin_q) begin
         if (count == '0) begin
            fin_q <= 1'b1;
         end else begin
            run    <= 1'b1;
            next_q <= tab_start;
         end
      end else if (hit) begin
         next_q <= next_q + IDX_W'(1);
         if (field_full) begin
            sum_q  <= sum_q + SUM_W'(merged[FIELD_W-1:0]);
            acc_q  <= merged >> FIELD_W;
            nb_q   <= nb_add - NB_W'(FIELD_W);
            nfld_q <= nfld_q + CNT_W'(1);
            if (nfld_q + CNT_W'(1) == count) begin
               run   <= 1'b0;
               fin_q <= 1'b1;
            end
         end else begin
            acc_q <= merged;
            nb_q  <= nb_add;
         end
      end
   end

   assign sum = sum_q;
   assign fin = fin_q;
endmodule

// File: rtl/isz_header_parse.sv
module isz_header_parse import isz_pkg::*; #(
   parameter int IDX_W       = 32,
   parameter int CNT_W       = 16,
   parameter int FIELD_W     = 22,
   parameter int FRAME_BYTES = 16,
   parameter int HS_OFS      = 24,
   parameter int CNT_OFS     = 55,
   parameter int ID_PAY      = 8,
   parameter int ID_TAB      = 5
) (
   input  logic                                             clk,
   input  logic                                             rst_n,
   input  logic                                             in_valid,
   input  logic                                             in_last,
   input  logic [IDX_W-1:0]                                 in_idx,
   input  logic [7:0]                                       in_byte,
   output logic [OFS_W-1:0]                                 payload_start,
   output logic [CNT_W+FIELD_W+$clog2(FRAME_BYTES)-1:0]     data_size,
   output logic                                             done,
   output logic                                             parse_err
);
   localparam int CNT_BYTES  = CNT_W / 8;
   localparam int SUM_W      = CNT_W + FIELD_W;
   localparam int FRAME_SH   = $clog2(FRAME_BYTES);
   localparam int SIZE_W     = SUM_W + FRAME_SH;
   localparam int MIN_HS     = HS_OFS + 2;
   localparam int MIN_TAB    = CNT_OFS + CNT_BYTES + 1;
   localparam bit FRAME_POW2 = ((1 << FRAME_SH) == FRAME_BYTES);

   generate
      if (CNT_W < 8 || (CNT_W % 8) != 0) begin : g_bad_cnt
         $error("CNT_W must be a positive multiple of 8");
      end
      if (IDX_W < 8 || IDX_W > 64) begin : g_bad_idx
         $error("IDX_W must lie in 8..64");
      end
      if (FIELD_W < 8 || FIELD_W > 32) begin : g_bad_field
         $error("FIELD_W must lie in 8..32");
      end
      if (FRAME_BYTES < 1) begin : g_bad_frame
         $error("FRAME_BYTES must be at least 1");
      end
      if (MIN_HS > 255 || HS_OFS >= CNT_OFS) begin : g_bad_ofs
         $error("header-size offset out of range");
      end
   endgenerate

   // header size byte
   logic       hs_known, hs_bad;
   logic [7:0] hs_q;
   logic       hs_hit, nrec_hit;

   assign hs_hit   = in_valid && (in_idx == IDX_W'(HS_OFS));
   assign nrec_hit = in_valid && hs_known && !hs_bad &&
                     (in_idx == IDX_W'(hs_q) - IDX_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hs_known <= 1'b0;
         hs_bad   <= 1'b0;
         hs_q     <= '0;
      end else if (hs_hit && !hs_known) begin
         hs_known <= 1'b1;
         hs_q     <= in_byte;
         hs_bad   <= (in_byte < 8'(MIN_HS));
      end
   end

   // component count, one register per byte
   logic [7:0]       cnt_b [CNT_BYTES];
   logic [CNT_W-1:0] comp_cnt;
   logic             cnt_known;

   for (genvar b = 0; b < CNT_BYTES; b++) begin : g_cnt
      always_ff @(posedge clk) begin
         if (!rst_n)
            cnt_b[b] <= '0;
         else if (in_valid && in_idx == IDX_W'(CNT_OFS + b))
            cnt_b[b] <= in_byte;
      end
      assign comp_cnt[8*b +: 8] = cnt_b[b];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_known <= 1'b0;
      else if (in_valid && in_idx == IDX_W'(CNT_OFS + CNT_BYTES - 1))
         cnt_known <= 1'b1;
   end

   // record table scan
   logic             scan_done, scan_ok, scan_late;
   logic [OFS_W-1:0] pay_ofs, tab_ofs;

   isz_rec_scan #(
      .IDX_W   (IDX_W),
      .ID_PAY  (ID_PAY),
      .ID_TAB  (ID_TAB),
      .MIN_TAB (MIN_TAB)
   ) u_scan (
      .clk       (clk),
      .rst_n     (rst_n),
      .arm       (nrec_hit),
      .base      (IDX_W'(hs_q)),
      .nrec      (in_byte),
      .in_valid  (in_valid),
      .in_idx    (in_idx),
      .in_byte   (in_byte),
      .scan_done (scan_done),
      .scan_ok   (scan_ok),
      .scan_late (scan_late),
      .pay_ofs   (pay_ofs),
      .tab_ofs   (tab_ofs)
   );

   // packed size summation
   logic             sum_go, sum_fin;
   logic [SUM_W-1:0] sum_w;

   assign sum_go = scan_done && scan_ok && !scan_late && cnt_known;

   isz_field_sum #(
      .IDX_W   (IDX_W),
      .CNT_W   (CNT_W),
      .FIELD_W (FIELD_W),
      .SUM_W   (SUM_W)
   ) u_sum (
      .clk       (clk),
      .rst_n     (rst_n),
      .go        (sum_go),
      .tab_start (IDX_W'(tab_ofs)),
      .count     (comp_cnt),
      .in_valid  (in_valid),
      .in_idx    (in_idx),
      .in_byte   (in_byte),
      .sum       (sum_w),
      .fin       (sum_fin)
   );

   // frame scaling
   logic [SIZE_W-1:0] scaled;
   generate
      if (FRAME_POW2) begin : g_shift
         assign scaled = SIZE_W'(sum_w) << FRAME_SH;
      end else begin : g_mult
         assign scaled = SIZE_W'(sum_w) * SIZE_W'(FRAME_BYTES);
      end
   endgenerate

   // result and error
   logic              ended_q, done_q, err_q, err_n;
   logic [OFS_W-1:0]  pay_o;
   logic [SIZE_W-1:0] size_o;

   assign err_n = hs_bad
               || (scan_done && (!scan_ok || scan_late))
               || (ended_q && !sum_fin);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ended_q <= 1'b0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
         pay_o   <= '0;
         size_o  <= '0;
      end else begin
         if (in_valid && in_last) ended_q <= 1'b1;
         if (!done_q && !err_q) begin
            if (err_n) begin
               err_q <= 1'b1;
            end else if (sum_fin) begin
               done_q <= 1'b1;
               pay_o  <= pay_ofs;
               size_o <= scaled;
            end
         end
      end
   end

   assign payload_start = pay_o;
   assign data_size     = size_o;
   assign done          = done_q;
   assign parse_err     = err_q;
endmodule

// File: rtl/isz_header_parse_chk.sv
module isz_header_parse_chk #(
   parameter int SIZE_W = 42
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_last,
   input logic [31:0]       payload_start,
   input logic [SIZE_W-1:0] data_size,
   input logic              done,
   input logic              parse_err
);
   // R1: outputs stay at zero until the result is ready
   a_r1_zero_until_done: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> (payload_start == '0 && data_size == '0));

   // R11: done and error exclude each other
   a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && parse_err));

   // R11: done is sticky
   a_r11_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> done);

   // R11: error is sticky
   a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      parse_err |=> parse_err);

   // R8: results hold once ready
   a_r8_result_stable: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> ($stable(data_size) && $stable(payload_start)));

   // R10: an end marker before the result leads to a verdict
   a_r10_end_verdict: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_last && !done) |=> ##1 (done || parse_err));
endmodule

bind isz_header_parse isz_header_parse_chk #(.SIZE_W(SIZE_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .in_valid      (in_valid),
   .in_last       (in_last),
   .payload_start (payload_start),
   .data_size     (data_size),
   .done          (done),
   .parse_err     (parse_err)
);

// File: tb/isz_header_parse_test.sv
module isz_header_parse_test;
   localparam int IDX_W  = 32;
   localparam int SIZE_W = 42;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              in_valid = 1'b0, in_last = 1'b0;
   logic [IDX_W-1:0]  in_idx = '0;
   logic [7:0]        in_byte = '0;
   logic [31:0]       payload_start;
   logic [SIZE_W-1:0] data_size;
   logic              done, parse_err;

   always #5 clk = ~clk;

   isz_header_parse #(.IDX_W(IDX_W)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
      .in_idx(in_idx), .in_byte(in_byte), .payload_start(payload_start),
      .data_size(data_size), .done(done), .parse_err(parse_err)
   );

   int     n_chk = 0, n_bad = 0;
   logic [7:0] img [0:511];
   int     g_hs, g_tab, g_pay, g_nbytes;
   longint g_size;

   // hs, ncomp, seed, payload-record-first, decoy record after both found
   localparam logic [41:0] VECS [0:5] = '{
      {8'd60,  16'd1,  16'h1234, 1'b1, 1'b0},
      {8'd64,  16'd2,  16'h0BEE, 1'b0, 1'b0},
      {8'd72,  16'd4,  16'h0042, 1'b1, 1'b1},
      {8'd96,  16'd7,  16'hF001, 1'b0, 1'b1},
      {8'd128, 16'd13, 16'h5A5A, 1'b1, 1'b0},
      {8'd200, 16'd40, 16'h0777, 1'b0, 1'b1}
   };

   task automatic check(string req, string what, longint act, longint exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic logic [21:0] comp_size(int seed, int i);
      logic [31:0] h;
      if (seed[15:12] == 4'hF) return 22'h3FFFFF;
      h = 32'(seed) * 32'd2654435761 + 32'(i) * 32'd40503 + 32'd977;
      return h[26:5];
   endfunction

   task automatic build(int hs, int ncomp, int seed, bit pay_first, bit decoy);
      int nrec;
      int kinds [4];
      int starts [4];
      logic [21:0] sz;
      for (int i = 0; i < 512; i++) img[i] = 8'(i * 37 + seed);
      nrec     = decoy ? 4 : 3;
      g_hs     = hs;
      g_tab    = hs + 9 * nrec + 3;
      g_nbytes = (22 * ncomp + 7) / 8;
      g_pay    = g_tab + g_nbytes + 5;
      img[24]     = 8'(hs);
      img[hs - 1] = 8'(nrec);
      img[55]     = 8'(ncomp);
      img[56]     = 8'(ncomp >> 8);
      kinds  = '{3, pay_first ? 8 : 5, pay_first ? 5 : 8, 8};
      starts = '{1000, pay_first ? g_pay : g_tab, pay_first ? g_tab : g_pay, g_pay + 100};
      for (int j = 0; j < nrec; j++) begin
         img[hs + 9 * j] = 8'(kinds[j]);
         for (int b = 0; b < 4; b++) img[hs + 9 * j + 1 + b] = 8'(starts[j] >> (8 * b));
      end
      for (int i = 0; i < g_nbytes; i++) img[g_tab + i] = 8'h00;
      g_size = 0;
      for (int i = 0; i < ncomp; i++) begin
         sz = comp_size(seed, i);
         g_size += longint'(sz);
         for (int b = 0; b < 22; b++) img[g_tab + (22 * i + b) / 8][(22 * i + b) % 8] = sz[b];
      end
      g_size = g_size * 16;
   endtask

   task automatic send(int first, int last_i, bit with_last, bit gaps);
      for (int i = first; i <= last_i; i++) begin
         @(negedge clk);
         if (gaps && (i % 5) == 3) begin
            in_valid = 1'b0;
            in_last  = 1'b0;
            @(negedge clk);
         end
         in_valid = 1'b1;
         in_idx   = IDX_W'(i);
         in_byte  = img[i];
         in_last  = with_last && (i == last_i);
      end
      @(negedge clk);
      in_valid = 1'b0;
      in_last  = 1'b0;
   endtask

   task automatic do_reset();
      in_valid = 1'b0;
      in_last  = 1'b0;
      rst_n    = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic run_full(bit gaps);
      send(0, g_pay - 1, 1'b1, gaps);
      repeat (4) @(negedge clk);
   endtask

   task automatic expect_err(string req, string what);
      check(req, {what, " parse_err"}, longint'(parse_err), 1);
      check(req, {what, " done"}, longint'(done), 0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      logic [41:0] v;
      do_reset();
      // R1 reset state
      check("R1", "done", longint'(done), 0);
      check("R1", "parse_err", longint'(parse_err), 0);
      check("R1", "payload_start", longint'(payload_start), 0);
      check("R1", "data_size", longint'(data_size), 0);

      // vector walk: R3 R4 R5 R8 R11
      for (int n = 0; n < 6; n++) begin
         v = VECS[n];
         do_reset();
         build(int'(v[41:34]), int'(v[33:18]), int'(v[17:2]), v[1], v[0]);
         run_full(n[0]);
         check("R11", $sformatf("vec%0d done", n), longint'(done), 1);
         check("R11", $sformatf("vec%0d parse_err", n), longint'(parse_err), 0);
         check("R3 R4 R5", $sformatf("vec%0d payload_start", n), longint'(payload_start), longint'(g_pay));
         check("R8", $sformatf("vec%0d data_size", n), longint'(data_size), g_size);
      end

      // R9 zero components
      do_reset();
      build(60, 0, 16'h0321, 1'b1, 1'b0);
      run_full(1'b0);
      check("R9", "done", longint'(done), 1);
      check("R9", "data_size", longint'(data_size), 0);

      // R2 header size too small
      do_reset();
      build(60, 3, 16'h0111, 1'b1, 1'b0);
      img[24] = 8'd20;
      run_full(1'b0);
      expect_err("R2", "small header");

      // R6 payload kind missing (record 1 turned to another kind)
      do_reset();
      build(60, 3, 16'h0222, 1'b1, 1'b0);
      img[60 + 9] = 8'd9;
      run_full(1'b0);
      expect_err("R6", "no payload record");

      // R4 zero start offset counts as absent
      do_reset();
      build(64, 3, 16'h0333, 1'b1, 1'b0);
      for (int b = 1; b <= 4; b++) img[64 + 9 + b] = 8'h00;
      run_full(1'b0);
      expect_err("R4", "zero start");

      // R6 zero records
      do_reset();
      build(64, 3, 16'h0444, 1'b1, 1'b0);
      img[63] = 8'd0;
      run_full(1'b0);
      expect_err("R6", "zero records");

      // R7 size table placed too early
      do_reset();
      build(60, 3, 16'h0555, 1'b1, 1'b0);
      img[60 + 18 + 1] = 8'd40;
      img[60 + 18 + 2] = 8'd0;
      img[60 + 18 + 3] = 8'd0;
      img[60 + 18 + 4] = 8'd0;
      run_full(1'b0);
      expect_err("R7", "early table");

      // R10 stream ends inside the size table
      do_reset();
      build(72, 5, 16'h0666, 1'b0, 1'b0);
      send(0, g_tab + 1, 1'b1, 1'b0);
      repeat (4) @(negedge clk);
      expect_err("R10", "truncated");

      // R11 exact latency, then stickiness through the end marker
      do_reset();
      build(60, 4, 16'h0888, 1'b1, 1'b0);
      send(0, g_tab + g_nbytes - 1, 1'b0, 1'b0);
      check("R11", "done after first edge", longint'(done), 0);
      @(negedge clk);
      check("R11", "done after second edge", longint'(done), 1);
      check("R8", "latency data_size", longint'(data_size), g_size);
      send(g_tab + g_nbytes, g_pay - 1, 1'b1, 1'b0);
      repeat (3) @(negedge clk);
      check("R11", "done sticky", longint'(done), 1);
      check("R11", "no error after end", longint'(parse_err), 0);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule